// File: doc/BRIEF.md
# Indexed Word Load Address Unit

This block forms the effective address of a 32-bit word load, works out the value to write back to the base register, and assembles the loaded word from a byte-wide memory. A load starts with a one-cycle request that carries a base value, a 12-bit unsigned immediate, an add/subtract select, an indexing mode and a byte-order select. The unit then reads four consecutive bytes, one per cycle, and places them into the word in little-endian or big-endian order.

There are three indexing modes. In offset mode the load uses base plus or minus the immediate as its address, and the base is left alone. In pre-indexed mode that same adjusted address is used and is also written back to the base. In post-indexed mode the load uses the unmodified base, and the adjusted value is written back after the access. The writeback value and its enable appear together with the completion pulse. The register file that consumes them sits outside this block.

Top module: `idxLoadUnit`

## Requirements
- R1: With modeSel = 2'b00 (offset), or the spare code 2'b11 which acts the same, the first read address is baseIn adjusted by the immediate, and baseWrEn stays low for the whole load.
- R2: With modeSel = 2'b01 (pre-indexed), the first read address is the adjusted base. In the done cycle baseWrEn is high and baseOut equals that same adjusted base.
- R3: With modeSel = 2'b10 (post-indexed), the first read address is the unmodified baseIn. In the done cycle baseWrEn is high and baseOut equals the adjusted base.
- R4: A request sampled at clock edge E drives memRdEn high for exactly the four cycles that follow E. memAddr takes the values A, A+1, A+2, A+3 in those cycles, where A is the access address. The byte on memRdData in a cycle belongs to the address shown in that same cycle.
- R5: With bigEndian = 0, the byte read from A lands in loadWord[7:0] and the byte from A+3 lands in loadWord[31:24].
- R6: With bigEndian = 1, the byte read from A lands in loadWord[31:24] and the byte from A+3 lands in loadWord[7:0].
- R7: offsetImm is a 12-bit unsigned value (0 to 4095). offsetUp = 1 adds it to baseIn and offsetUp = 0 subtracts it.
- R8: Every address and writeback sum is 32 bits wide and wraps modulo 2^32, including the A+1 to A+3 byte addresses.
- R9: done is high for exactly one cycle, the cycle after the fourth read. loadWord is valid in that cycle. baseWrEn is high only in a done cycle of a pre-indexed or post-indexed load.
- R10: startReq is ignored while the four reads are in progress. A request held high through the done cycle is accepted in that done cycle.
- R11: While rstN is low, and in the first cycle after it is released, done, baseWrEn and memRdEn are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Synchronous active-low reset |
| startReq | input | 1 | Load request, sampled when the unit is idle |
| baseIn | input | 32 | Base register value |
| offsetImm | input | 12 | Unsigned immediate offset |
| offsetUp | input | 1 | 1 adds the offset, 0 subtracts it |
| modeSel | input | 2 | 00 offset, 01 pre-indexed, 10 post-indexed, 11 acts as offset |
| bigEndian | input | 1 | 1 selects big-endian byte order |
| memAddr | output | 32 | Byte address being read |
| memRdEn | output | 1 | Byte read strobe |
| memRdData | input | 8 | Byte returned for memAddr in the same cycle |
| loadWord | output | 32 | Assembled word, valid when done is high |
| baseOut | output | 32 | Base writeback value, valid with baseWrEn |
| baseWrEn | output | 1 | Base writeback enable |
| done | output | 1 | One-cycle completion pulse |

## Verification
The completion of one load and the acceptance of the next can fall in the same cycle. The bench provokes this by holding startReq high over many cycles while baseIn changes each cycle. This checks that the requests made during the reads are dropped and that the request present in the done cycle starts a new burst straight away. A behavioural model built from counters decides, every clock, which request should have been taken and which addresses, done pulse, writeback and word must follow. Both mid-burst requests and back-to-back bursts are therefore judged cycle by cycle against the ports.

// File: rtl/idxLoadPkg.sv
package idxLoadPkg;
  localparam int LANES      = 4;
  localparam int LANE_IDX_W = $clog2(LANES);

  typedef enum logic [1:0] {
    MODE_OFFSET = 2'b00,
    MODE_PRE    = 2'b01,
    MODE_POST   = 2'b10,
    MODE_SPARE  = 2'b11
  } idxMode_e;

  typedef struct packed {
    logic                  latch;
    logic                  capture;
    logic                  finish;
    logic [LANE_IDX_W-1:0] byteIdx;
  } ctrlStrobe_t;
endpackage

// File: rtl/idxLoadCtrl.sv
module idxLoadCtrl
  import idxLoadPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  output ctrlStrobe_t strobe,
  output logic        memRdEn,
  output logic        done
);
  localparam logic [LANE_IDX_W-1:0] LAST_IDX = LANE_IDX_W'(LANES - 1);

  logic                  busy;
  logic [LANE_IDX_W-1:0] cnt;
  logic                  doneQ;

  always_comb begin
    strobe         = '0;
    strobe.latch   = !busy && startReq;
    strobe.capture = busy;
    strobe.finish  = doneQ;
    strobe.byteIdx = cnt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy  <= 1'b0;
      cnt   <= '0;
      doneQ <= 1'b0;
    end else begin
      doneQ <= busy && (cnt == LAST_IDX);
      if (strobe.latch) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
        if (cnt == LAST_IDX) busy <= 1'b0;
      end
    end
  end

  assign memRdEn = busy;
  assign done    = doneQ;

  // R9
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);
  // R4
  read_after_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(startReq));
  // R9
  done_after_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |-> $past(busy));
endmodule

// File: rtl/idxLoadPath.sv
module idxLoadPath
  import idxLoadPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strobe,
  input  logic [ADDR_W-1:0]   baseIn,
  input  logic [OFF_W-1:0]    offsetImm,
  input  logic                offsetUp,
  input  logic [1:0]          modeSel,
  input  logic                bigEndian,
  input  logic [7:0]          memRdData,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [LANES*8-1:0]  loadWord,
  output logic [ADDR_W-1:0]   baseOut,
  output logic                baseWrEn
);
  localparam int                    WORD_W   = LANES * 8;
  localparam logic [LANE_IDX_W-1:0] LAST_IDX = LANE_IDX_W'(LANES - 1);

  idxMode_e              modeNow;
  logic [ADDR_W-1:0]     adjSum;
  logic [ADDR_W-1:0]     accessAddr;
  logic [ADDR_W-1:0]     wbValue;
  logic                  wbFlag;
  logic                  beFlag;
  logic [WORD_W-1:0]     wordQ;
  logic [LANE_IDX_W-1:0] laneSel;

  assign modeNow = idxMode_e'(modeSel);
  assign adjSum  = offsetUp ? (baseIn + ADDR_W'(offsetImm))
                            : (baseIn - ADDR_W'(offsetImm));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accessAddr <= '0;
      wbValue    <= '0;
      wbFlag     <= 1'b0;
      beFlag     <= 1'b0;
    end else if (strobe.latch) begin
      accessAddr <= (modeNow == MODE_POST) ? baseIn : adjSum;
      wbValue    <= adjSum;
      wbFlag     <= (modeNow == MODE_PRE) || (modeNow == MODE_POST);
      beFlag     <= bigEndian;
    end
  end

  assign laneSel = beFlag ? (LAST_IDX - strobe.byteIdx) : strobe.byteIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordQ <= '0;
    end else if (strobe.capture) begin
      for (int lane = 0; lane < LANES; lane++) begin
        if (laneSel == LANE_IDX_W'(lane)) wordQ[lane*8 +: 8] <= memRdData;
      end
    end
  end

  assign memAddr  = accessAddr + ADDR_W'(strobe.byteIdx);
  assign loadWord = wordQ;
  assign baseOut  = wbValue;
  assign baseWrEn = strobe.finish && wbFlag;

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && $past(strobe.capture)) |-> (memAddr == $past(memAddr) + 1'b1));
  // R9
  wb_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.finish && $past(strobe.capture)) |-> $stable(wbValue));
endmodule

// File: rtl/idxLoadUnit.sv
module idxLoadUnit
  import idxLoadPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startReq,
  input  logic [ADDR_W-1:0]  baseIn,
  input  logic [OFF_W-1:0]   offsetImm,
  input  logic               offsetUp,
  input  logic [1:0]         modeSel,
  input  logic               bigEndian,
  output logic [ADDR_W-1:0]  memAddr,
  output logic               memRdEn,
  input  logic [7:0]         memRdData,
  output logic [LANES*8-1:0] loadWord,
  output logic [ADDR_W-1:0]  baseOut,
  output logic               baseWrEn,
  output logic               done
);
  ctrlStrobe_t strobe;

  idxLoadCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .strobe   (strobe),
    .memRdEn  (memRdEn),
    .done     (done)
  );

  idxLoadPath #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .baseIn    (baseIn),
    .offsetImm (offsetImm),
    .offsetUp  (offsetUp),
    .modeSel   (modeSel),
    .bigEndian (bigEndian),
    .memRdData (memRdData),
    .memAddr   (memAddr),
    .loadWord  (loadWord),
    .baseOut   (baseOut),
    .baseWrEn  (baseWrEn)
  );

  // R9
  wb_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    baseWrEn |-> (done && $past(memRdEn)));
  // R11
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |=> (!done && !baseWrEn && !memRdEn));
endmodule

// File: tb/idxLoadUnit_bench.sv
module idxLoadUnit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic [31:0] baseIn = '0;
  logic [11:0] offsetImm = '0;
  logic        offsetUp = 1'b1;
  logic [1:0]  modeSel = 2'b00;
  logic        bigEndian = 1'b0;
  logic [31:0] memAddr;
  logic        memRdEn;
  logic [7:0]  memRdData;
  logic [31:0] loadWord;
  logic [31:0] baseOut;
  logic        baseWrEn;
  logic        done;

  logic [7:0] mem [256];
  int nChecks = 0;
  int nFail = 0;
  string phase = "reset";

  always #(CLK_PERIOD/2) clk = ~clk;
  assign memRdData = mem[memAddr[7:0]];

  idxLoadUnit u_idxLoadUnit (
    .clk(clk), .rstN(rstN), .startReq(startReq), .baseIn(baseIn),
    .offsetImm(offsetImm), .offsetUp(offsetUp), .modeSel(modeSel),
    .bigEndian(bigEndian), .memAddr(memAddr), .memRdEn(memRdEn),
    .memRdData(memRdData), .loadWord(loadWord), .baseOut(baseOut),
    .baseWrEn(baseWrEn), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s [%s] actual=%h expected=%h", tag, phase, act, exp);
    end
  endtask

  // behavioural reference model
  bit          busyM = 0;
  int          cntM = 0;
  bit          doneM = 0;
  logic [31:0] addrM, wbM, wordM;
  bit          wbEnM = 0;
  bit          beM = 0;
  int          modeM = 0;

  always @(posedge clk) begin
    logic [31:0] s;
    if (!rstN) begin
      busyM = 0; cntM = 0; doneM = 0;
    end else begin
      doneM = 0;
      if (busyM) begin
        if (cntM == 3) begin busyM = 0; doneM = 1; end
        else cntM++;
      end else if (startReq) begin
        s = offsetUp ? baseIn + {20'd0, offsetImm} : baseIn - {20'd0, offsetImm};
        addrM = (modeSel == 2'b10) ? baseIn : s;
        wbM   = s;
        wbEnM = (modeSel == 2'b01) || (modeSel == 2'b10);
        beM   = bigEndian;
        modeM = int'(modeSel);
        busyM = 1; cntM = 0;
      end
      if (doneM) begin
        for (int k = 0; k < 4; k++) begin
          logic [31:0] a;
          a = addrM + k;
          if (beM) wordM[(3-k)*8 +: 8] = mem[a[7:0]];
          else     wordM[k*8 +: 8]     = mem[a[7:0]];
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      chk(memRdEn == busyM, "R4", {31'd0, memRdEn}, {31'd0, busyM});
      if (busyM) chk(memAddr == addrM + cntM, "R4", memAddr, addrM + cntM);
      chk(done == doneM, "R9", {31'd0, done}, {31'd0, doneM});
      chk(baseWrEn == (doneM && wbEnM), "R9", {31'd0, baseWrEn}, {31'd0, doneM && wbEnM});
      if (doneM) begin
        chk(loadWord == wordM, beM ? "R6" : "R5", loadWord, wordM);
        if (wbEnM) chk(baseOut == wbM, (modeM == 1) ? "R2" : "R3", baseOut, wbM);
        else       chk(!baseWrEn, "R1", {31'd0, baseWrEn}, 32'd0);
      end
    end
  end

  logic [31:0] gotWord, gotBase;
  bit          gotWb;

  task automatic runLoad(input logic [31:0] b, input logic [11:0] o, input bit up,
                         input logic [1:0] m, input bit be);
    @(negedge clk);
    baseIn = b; offsetImm = o; offsetUp = up; modeSel = m; bigEndian = be;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    for (int w = 0; w < 10; w++) begin
      if (done) break;
      @(negedge clk);
    end
    gotWord = loadWord; gotBase = baseOut; gotWb = baseWrEn;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
    mem[0] = 8'h0D; mem[1] = 8'hEB; mem[2] = 8'h2C; mem[3] = 8'h1A;
    mem[4] = 8'h79; mem[5] = 8'hCD; mem[6] = 8'hA3; mem[7] = 8'hFD;
    repeat (3) @(negedge clk);
    chk(!done && !baseWrEn && !memRdEn, "R11", {29'd0, done, baseWrEn, memRdEn}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!done && !baseWrEn && !memRdEn, "R11", {29'd0, done, baseWrEn, memRdEn}, 32'd0);

    phase = "R5 little";
    runLoad(32'h20008000, 12'd0, 1'b1, 2'b00, 1'b0);
    chk(gotWord == 32'h1A2CEB0D, "R5", gotWord, 32'h1A2CEB0D);
    chk(!gotWb, "R1", {31'd0, gotWb}, 32'd0);
    phase = "R6 big";
    runLoad(32'h20008000, 12'd0, 1'b1, 2'b00, 1'b1);
    chk(gotWord == 32'h0DEB2C1A, "R6", gotWord, 32'h0DEB2C1A);
    phase = "R1 offset";
    runLoad(32'h20008000, 12'd4, 1'b1, 2'b00, 1'b0);
    chk(gotWord == 32'hFDA3CD79, "R1", gotWord, 32'hFDA3CD79);
    phase = "R2 pre";
    runLoad(32'h20008000, 12'd4, 1'b1, 2'b01, 1'b0);
    chk(gotWord == 32'hFDA3CD79, "R2", gotWord, 32'hFDA3CD79);
    chk(gotWb && gotBase == 32'h20008004, "R2", gotBase, 32'h20008004);
    phase = "R3 post";
    runLoad(32'h20008000, 12'd4, 1'b1, 2'b10, 1'b0);
    chk(gotWord == 32'h1A2CEB0D, "R3", gotWord, 32'h1A2CEB0D);
    chk(gotWb && gotBase == 32'h20008004, "R3", gotBase, 32'h20008004);
    phase = "R1 spare";
    runLoad(32'h20008040, 12'd3, 1'b1, 2'b11, 1'b1);
    chk(!gotWb, "R1", {31'd0, gotWb}, 32'd0);
    phase = "R7";
    runLoad(32'h20008010, 12'd12, 1'b0, 2'b01, 1'b1);
    chk(gotBase == 32'h20008004, "R7", gotBase, 32'h20008004);
    chk(gotWord == 32'h79CDA3FD, "R7", gotWord, 32'h79CDA3FD);
    runLoad(32'h00001000, 12'hFFF, 1'b1, 2'b10, 1'b0);
    chk(gotBase == 32'h00001FFF, "R7", gotBase, 32'h00001FFF);
    phase = "R8";
    runLoad(32'hFFFFFFFE, 12'd0, 1'b1, 2'b00, 1'b0);
    runLoad(32'h00000002, 12'd5, 1'b0, 2'b01, 1'b1);
    chk(gotBase == 32'hFFFFFFFD, "R8", gotBase, 32'hFFFFFFFD);
    runLoad(32'hFFFFFFF0, 12'h020, 1'b1, 2'b10, 1'b0);
    chk(gotBase == 32'h00000010, "R8", gotBase, 32'h00000010);

    phase = "R10";
    @(negedge clk);
    startReq = 1'b1; modeSel = 2'b01; offsetImm = 12'd1; offsetUp = 1'b1;
    for (int c = 0; c < 17; c++) begin
      baseIn = 32'h20008000 + 32'(c * 8);
      bigEndian = c[0];
      @(negedge clk);
    end
    startReq = 1'b0;
    repeat (8) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog [%s] actual=%h expected=%h", phase, 32'd1, 32'd0);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule